// File: doc/BRIEF.md
# Spare-Core Calibration Swap Sequencer

This block sequences calibration for a converter whose four input channels are served by six sample cores. Channels A, B, C and D are normally fed by cores 0, 1, 4 and 5. Cores 2 and 3 are spares. The block selects which core feeds each channel output. It also drives a calibrate request to an external calibration engine for one core at a time in each spare group, and waits for that core's done pulse. The engine corrects linearity, gain and offset.

A start pulse begins one pass. The mode select sampled with that pulse picks the kind of pass. A foreground pass takes the channel outputs offline, so they read zero, the mid-scale code in two's complement. It then calibrates cores 0, 1, 4 and 5 in that order. A background pass keeps the outputs live. In each group, the spare is calibrated first. The spare then stands in for the first working core while that core is calibrated, and then for the second. Finally the normal mapping is restored. Core 2 covers cores 0 and 1; core 3 covers cores 4 and 5. The two groups advance independently. Every change of routing waits for a sample strobe.

Top module: `cal_swap_seq`

## Requirements
- R1: After reset, busy is 0, no calibrate request is active and every channel carries its home core.
- R2: When idle, channel A carries core 0, B carries core 1, C carries core 4 and D carries core 5. ch_valid always equals core_valid.
- R3: A start pulse with mode_bg=0 sets busy on the next cycle. While that foreground pass runs, all four channel words are zero.
- R4: A foreground pass requests cores 0, 1, 4, 5 in that order. Exactly one request is active at a time, and each is held until the done bit of that same core arrives. Done bits of other cores are ignored.
- R5: In the cycle after the done pulse of core 5, busy is 0, no request is active and the channels carry live home-core data.
- R6: A start pulse with mode_bg=1 runs, in each group, this sequence: calibrate the spare, calibrate the first worker while the spare feeds its channel, calibrate the second worker while the spare feeds its channel, restore. Core 2 serves cores 0 and 1; core 3 serves cores 4 and 5. The two groups progress independently, and busy falls once both have restored.
- R7: A routing change happens only on a clock edge where core_valid is 1. The displaced core's request becomes active in the same cycle the spare is seen on its channel.
- R8: No channel ever carries data from a core whose calibrate request is active, and background passes never zero the outputs.
- R9: A start pulse or a mode_bg change during busy has no effect on the running pass. The block is idle after that pass ends.
- R10: Core c occupies core_data bits [c*W +: W], channel k (A=0..D=3) occupies ch_data bits [k*W +: W], and bit c of cal_req/cal_done belongs to core c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_bg | input | 1 | Pass type at start: 0 foreground, 1 background |
| start | input | 1 | Start pulse |
| cal_done | input | 6 | Per-core calibration done pulse |
| core_valid | input | 1 | Sample strobe of the cores |
| core_data | input | 6*SAMPLE_W | Sample words of the six cores |
| cal_req | output | 6 | Per-core calibrate request |
| ch_data | output | 4*SAMPLE_W | Channel output words A..D |
| ch_valid | output | 1 | Channel output strobe |
| busy | output | 1 | A calibration pass is running |

## Verification
Some properties are checked on every cycle by the assertions:
- no channel is ever sourced from a core under calibration;
- the outputs are zero throughout a foreground pass;
- the request count stays bounded;
- routing changes only after a sample strobe;
- the foreground pass releases busy right after its last done;
- a foreground and a background pass never overlap.

Other behaviour can only be shown by the bench's scenarios:
- the order in which the cores are visited;
- that done bits of the wrong core are ignored;
- how long a swap waits while the strobe stays low;
- which spare lands on which channel;
- that starts arriving mid-pass are dropped.

// File: rtl/cal_swap_pkg.sv
package cal_swap_pkg;
  localparam int NCORE = 6;
  localparam int NCH   = 4;
  localparam int NGRP  = 2;
  localparam int IDXW  = 3;

  typedef enum logic [2:0] {
    G_IDLE, G_CAL_SPARE, G_SWAP_A, G_CAL_A, G_SWAP_B, G_CAL_B, G_RESTORE
  } grp_st_t;

  // working core at position pos (0/1) of group g
  function automatic int worker_core(input int g, input int pos);
    return g * 4 + pos;
  endfunction

  function automatic int spare_core(input int g);
    return 2 + g;
  endfunction

  // home core of channel ch; also the foreground visiting order
  function automatic int home_core(input int ch);
    return worker_core(ch / 2, ch % 2);
  endfunction

  // core feeding channel ch given its group's substitution code
  // (0 none, 1 spare replaces first worker, 2 spare replaces second)
  function automatic int src_core(input int ch, input logic [1:0] sub);
    if (int'(sub) == (ch % 2) + 1) return spare_core(ch / 2);
    return home_core(ch);
  endfunction
endpackage

// File: rtl/fg_walker.sv
module fg_walker
  import cal_swap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NCORE-1:0] cal_done,
  output logic [NCORE-1:0] req,
  output logic             busy,
  output logic             last_done
);
  logic       active;
  logic [1:0] idx;
  int         cur;
  logic       cur_done;

  always_comb begin
    cur       = home_core(int'(idx));
    cur_done  = active && cal_done[cur];
    last_done = cur_done && (idx == 2'd3);
    req       = active ? (NCORE'(1) << cur) : '0;
    busy      = active;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= 2'd0;
    end else if (go) begin
      active <= 1'b1;
      idx    <= 2'd0;
    end else if (cur_done) begin
      if (idx == 2'd3) active <= 1'b0;
      else             idx    <= idx + 2'd1;
    end
  end

  // R5
  fg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> !busy);
  // R4
  fg_single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(req) == 1);
endmodule

// File: rtl/bg_group.sv
module bg_group
  import cal_swap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       core_valid,
  input  logic       spare_done,
  input  logic       wa_done,
  input  logic       wb_done,
  output logic       req_spare,
  output logic       req_a,
  output logic       req_b,
  output logic [1:0] sub,
  output logic       busy
);
  grp_st_t st;
  logic    swap_now;

  always_comb begin
    req_spare = (st == G_CAL_SPARE);
    req_a     = (st == G_CAL_A);
    req_b     = (st == G_CAL_B);
    busy      = (st != G_IDLE);
    swap_now  = core_valid &&
                (st == G_SWAP_A || st == G_SWAP_B || st == G_RESTORE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= G_IDLE;
      sub <= 2'd0;
    end else begin
      case (st)
        G_IDLE:      if (go)         st <= G_CAL_SPARE;
        G_CAL_SPARE: if (spare_done) st <= G_SWAP_A;
        G_SWAP_A:    if (swap_now) begin sub <= 2'd1; st <= G_CAL_A; end
        G_CAL_A:     if (wa_done)    st <= G_SWAP_B;
        G_SWAP_B:    if (swap_now) begin sub <= 2'd2; st <= G_CAL_B; end
        G_CAL_B:     if (wb_done)    st <= G_RESTORE;
        G_RESTORE:   if (swap_now) begin sub <= 2'd0; st <= G_IDLE; end
        default:     st <= G_IDLE;
      endcase
    end
  end

  // R7
  swap_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sub) |-> $past(core_valid));
  // R8
  displaced_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_a |-> sub == 2'd1) and (req_b |-> sub == 2'd2) and (req_spare |-> sub == 2'd0));
endmodule

// File: rtl/ch_router.sv
module ch_router
  import cal_swap_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [NCORE*W-1:0]   core_data,
  input  logic [NGRP*2-1:0]    sub_sel,
  input  logic                 blank,
  output logic [NCH*W-1:0]     ch_data,
  output logic [NCH*IDXW-1:0]  src_idx
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [IDXW-1:0] s;
    assign s = IDXW'(src_core(k, sub_sel[(k/2)*2 +: 2]));
    assign src_idx[k*IDXW +: IDXW] = s;
    assign ch_data[k*W +: W] = blank ? '0 : core_data[int'(s)*W +: W];
  end
endmodule

// File: rtl/cal_swap_seq.sv
module cal_swap_seq
  import cal_swap_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_bg,
  input  logic                    start,
  input  logic [NCORE-1:0]        cal_done,
  input  logic                    core_valid,
  input  logic [NCORE*SAMPLE_W-1:0] core_data,
  output logic [NCORE-1:0]        cal_req,
  output logic [NCH*SAMPLE_W-1:0] ch_data,
  output logic                    ch_valid,
  output logic                    busy
);
  logic                   start_ok, fg_go, bg_go;
  logic                   fg_busy, fg_last;
  logic [NCORE-1:0]       fg_req;
  logic [NGRP-1:0]        grp_busy;
  logic [NGRP*2-1:0]      sub_sel;
  logic [NCORE-1:0]       grp_req [NGRP];
  logic [NCH*IDXW-1:0]    src_idx;
  logic                   bg_busy;

  assign bg_busy  = |grp_busy;
  assign busy     = fg_busy | bg_busy;
  assign start_ok = start && !busy;
  assign fg_go    = start_ok && !mode_bg;
  assign bg_go    = start_ok && mode_bg;
  assign ch_valid = core_valid;

  fg_walker u_fg (
    .clk(clk), .rst_n(rst_n), .go(fg_go), .cal_done(cal_done),
    .req(fg_req), .busy(fg_busy), .last_done(fg_last)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic rs, ra, rb;
    bg_group u_grp (
      .clk(clk), .rst_n(rst_n), .go(bg_go), .core_valid(core_valid),
      .spare_done(cal_done[spare_core(g)]),
      .wa_done(cal_done[worker_core(g, 0)]),
      .wb_done(cal_done[worker_core(g, 1)]),
      .req_spare(rs), .req_a(ra), .req_b(rb),
      .sub(sub_sel[g*2 +: 2]), .busy(grp_busy[g])
    );
    always_comb begin
      grp_req[g] = '0;
      grp_req[g][spare_core(g)]     = rs;
      grp_req[g][worker_core(g, 0)] = ra;
      grp_req[g][worker_core(g, 1)] = rb;
    end
  end

  always_comb begin
    cal_req = fg_req;
    for (int g = 0; g < NGRP; g++) cal_req = cal_req | grp_req[g];
  end

  ch_router #(.W(SAMPLE_W)) u_route (
    .core_data(core_data), .sub_sel(sub_sel), .blank(fg_busy),
    .ch_data(ch_data), .src_idx(src_idx)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    // R8
    no_cal_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fg_busy |-> !cal_req[src_idx[k*IDXW +: IDXW]]);
  end

  // R3
  fg_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fg_busy |-> ch_data == '0);
  // R6
  req_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cal_req) <= NGRP);
  // R9
  pass_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fg_busy && bg_busy));
endmodule

// File: tb/cal_swap_seq_test.sv
`timescale 1ns/1ps
module cal_swap_seq_test;
  localparam int W = 12;
  logic clk = 0, rst_n = 0, mode_bg = 0, start = 0, core_valid = 1;
  logic [5:0] cal_done = '0;
  logic [6*W-1:0] core_data;
  logic [5:0] cal_req;
  logic [4*W-1:0] ch_data;
  logic ch_valid, busy;
  logic [7:0] cnt = 0;
  int n_cmp = 0, n_bad = 0;
  bit fg_phase = 0, ended = 0;

  always #2 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 8'd1;

  for (genvar c = 0; c < 6; c++) begin : g_src
    assign core_data[c*W +: W] = {4'(c + 1), cnt};
  end

  cal_swap_seq #(.SAMPLE_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .mode_bg(mode_bg), .start(start),
    .cal_done(cal_done), .core_valid(core_valid), .core_data(core_data),
    .cal_req(cal_req), .ch_data(ch_data), .ch_valid(ch_valid), .busy(busy)
  );

  function automatic int home(input int k);
    return (k < 2) ? k : k + 2;
  endfunction

  function automatic logic [W-1:0] chv(input int k);
    return ch_data[k*W +: W];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // channel k must carry core c right now
  task automatic chk_src(input int k, input int c, input string tag);
    check(chv(k) == {4'(c + 1), cnt}, tag, int'(chv(k)), int'({4'(c + 1), cnt}));
  endtask

  // continuous monitor: R8 / R2 / R3
  always @(negedge clk) begin
    #1;
    if (rst_n && !ended) begin
      check(ch_valid == core_valid, "R2 ch_valid", ch_valid, core_valid);
      for (int k = 0; k < 4; k++) begin
        if (chv(k) == '0) begin
          check(fg_phase && busy, "R8 zero output outside foreground", 0, 1);
        end else begin
          int s;
          s = int'(chv(k)[W-1 -: 4]) - 1;
          check(!cal_req[s], "R8 source under calibration", s, k);
          if (!busy) check(s == home(k), "R2 idle mapping", s, home(k));
        end
      end
    end
  end

  task automatic serve(input int c, input string tag);
    check(cal_req[c] == 1'b1, tag, cal_req, 1 << c);
    @(negedge clk) cal_done[c] = 1'b1;
    @(negedge clk) cal_done[c] = 1'b0;
    #1;
  endtask

  task automatic step;
    @(negedge clk); #1;
  endtask

  initial begin
    #(4 * 20000);
    if (!ended) begin
      ended = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R1
    check(busy == 0, "R1 busy", busy, 0);
    check(cal_req == 0, "R1 req", cal_req, 0);
    for (int k = 0; k < 4; k++) chk_src(k, home(k), "R1 home map");
    step();
    // R2 / R10
    chk_src(0, 0, "R2 A"); chk_src(1, 1, "R2 B"); chk_src(2, 4, "R2 C"); chk_src(3, 5, "R10 D");

    // foreground pass
    fg_phase = 1;
    @(negedge clk) begin mode_bg = 0; start = 1; end
    @(negedge clk) start = 0;
    #1;
    check(busy == 1, "R3 busy", busy, 1);
    check(ch_data == 0, "R3 blank", int'(ch_data[31:0]), 0);
    check(cal_req == 6'd1, "R4 first req", cal_req, 1);
    @(negedge clk) cal_done[1] = 1;
    @(negedge clk) cal_done[1] = 0;
    #1;
    check(cal_req == 6'd1, "R4 foreign done ignored", cal_req, 1);
    serve(0, "R4 core0");
    check(cal_req == 6'd2, "R4 then core1", cal_req, 2);
    serve(1, "R4 core1");
    check(cal_req == 6'd16, "R4 then core4", cal_req, 16);
    serve(4, "R4 core4");
    check(cal_req == 6'd32, "R4 then core5", cal_req, 32);
    @(negedge clk) begin start = 1; mode_bg = 1; end
    @(negedge clk) start = 0;
    #1;
    check(busy == 1 && cal_req == 6'd32, "R9 start during fg", cal_req, 32);
    check(ch_data == 0, "R3 still blank", int'(ch_data[31:0]), 0);
    serve(5, "R4 core5");
    check(busy == 0, "R5 busy clear", busy, 0);
    check(cal_req == 0, "R5 req clear", cal_req, 0);
    chk_src(0, 0, "R5 live A");
    chk_src(3, 5, "R5 live D");
    fg_phase = 0;
    step(); step();
    check(busy == 0, "R9 dropped start", busy, 0);

    // background pass
    @(negedge clk) begin mode_bg = 1; start = 1; end
    @(negedge clk) start = 0;
    #1;
    check(busy == 1, "R6 busy", busy, 1);
    check(cal_req == 6'd12, "R6 spares first", cal_req, 12);
    core_valid = 0;
    serve(2, "R6 spare2");
    check(cal_req == 6'd8, "R7 wait strobe", cal_req, 8);
    step(); step();
    check(cal_req == 6'd8, "R7 still waiting", cal_req, 8);
    chk_src(0, 0, "R7 A not swapped");
    @(negedge clk) core_valid = 1;
    #1;
    step();
    check(cal_req == 6'd9, "R7 req with swap", cal_req, 9);
    chk_src(0, 2, "R7 A from spare2");
    serve(3, "R6 spare3");
    check(cal_req == 6'd1, "R6 grp1 swapping", cal_req, 1);
    step();
    check(cal_req == 6'd17, "R6 core4 req", cal_req, 17);
    chk_src(2, 3, "R6 C from spare3");
    serve(0, "R6 core0");
    check(cal_req == 6'd16, "R6 grp0 moving", cal_req, 16);
    step();
    check(cal_req == 6'd18, "R6 core1 req", cal_req, 18);
    chk_src(0, 0, "R6 A back home");
    chk_src(1, 2, "R6 B from spare2");
    serve(4, "R6 core4");
    step();
    check(cal_req == 6'd34, "R6 core5 req", cal_req, 34);
    chk_src(2, 4, "R6 C back home");
    chk_src(3, 3, "R6 D from spare3");
    serve(1, "R6 core1");
    step();
    check(cal_req == 6'd32, "R6 grp0 restored", cal_req, 32);
    chk_src(1, 1, "R6 B home");
    serve(5, "R6 core5");
    check(busy == 1, "R6 restoring", busy, 1);
    step();
    check(busy == 0 && cal_req == 0, "R6 pass end", busy, 0);
    for (int k = 0; k < 4; k++) chk_src(k, home(k), "R6 final map");

    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule